// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Register

This block holds outgoing data in a two-stage chain of byte registers and sends it out one bit at a time, most significant bit first, at a rate set by a prescaler. A host loads bytes with a single-cycle write strobe. The front stage feeds the serial output. The back stage takes each new byte. Both stages start as the alternating pattern AAh, so a transmission that begins before any write sends a 1010 preamble at no cost.

While transmit is disabled, each accepted write pushes the chain along: the back stage moves to the front and the new byte enters the back. Once transmit is enabled, the prescaler produces a bit tick. After eight ticks the back byte moves to the front and the back stage is refilled with AAh. A ready flag tells the host when the back stage can take a byte. The flag leaves the block as a data bit and an output enable, and the pad's tri-state buffer sits outside the block. The enable is low while chip select is high. Clearing transmit enable returns both stages to AAh.

Top module: `dtx_top`

## Requirements
- R1: When `buf_en` is low, `wr_stb` changes nothing: not the serial output, not the ready flag, not the queued bytes.
- R2: While `tx_en` is low and `buf_en` is high, each write moves the back byte to the front and places `wr_data` in the back. After two writes and a rise of `tx_en`, the first byte written is sent first and the second byte follows it.
- R3: After reset both stages hold AAh and `ser_out` is 1. If no byte is written, the line carries the repeating pattern 1,0,1,0.
- R4: In the first cycle that `tx_en` is low after being high, both stages return to AAh. A write in that same cycle is discarded.
- R5: Bits leave most significant bit first. Each bit is held for `bit_period`+1 clock cycles. The prescaler count restarts from zero while `tx_en` is low.
- R6: After eight bit times the back byte moves to the front with no gap, and the back stage is reloaded with AAh. A slot that is not written therefore sends AAh.
- R7: While `tx_en` is low, the ready flag is 1. While `tx_en` is high, an accepted write clears the flag one cycle later, and a byte transfer sets it again.
- R8: While `tx_en` is high and the ready flag is 0, a write is dropped.
- R9: `stat_oe` is the inverse of `cs_n`. `stat_d` carries the ready flag.
- R10: A write that arrives with the ready flag high, in the same cycle as a byte transfer, lands in the freed back stage and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_en | input | 1 | Buffered-mode enable; writes are ignored when low |
| tx_en | input | 1 | Transmit enable |
| bit_period | input | DIV_W | Prescaler limit; one bit lasts bit_period+1 cycles |
| wr_stb | input | 1 | Single-cycle byte write strobe |
| wr_data | input | DATA_W | Byte to load |
| cs_n | input | 1 | Active-low chip select for the status output |
| ser_out | output | 1 | Serial transmit data |
| stat_d | output | 1 | Ready flag, data for the status pad |
| stat_oe | output | 1 | Status pad output enable |

## Verification
A write that is accepted on an edge shows on `stat_d` in the sample after that edge. A prescaler tick taken on an edge moves `ser_out` to its next bit one cycle later, so each bit occupies exactly `bit_period`+1 samples. A byte transfer also raises the ready flag in that same following sample. The bench's behavioural model advances on the same edge the design uses and then compares `ser_out`, `stat_d` and `stat_oe` at the next falling edge. Stimulus changes only after that comparison. The bench picks the cycle of a boundary write from the model's own prescaler and bit position.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PREAMBLE = 8'hAA;
endpackage

// File: rtl/dtx_rate_gen.sv
module dtx_rate_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtx_bit_ctr.sv
module dtx_bit_ctr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic last
);
  localparam int unsigned CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] TOP = CW'(DATA_W - 1);

  logic [CW-1:0] bit_q;

  assign last = tick && (bit_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run) bit_q <= '0;
    else if (last)   bit_q <= '0;
    else if (tick)   bit_q <= bit_q + 1'b1;
  end
endmodule

// File: rtl/dtx_chain.sv
module dtx_chain #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic              xfer,
  input  logic              shift,
  input  logic              put,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);
  logic [DATA_W-1:0] front_q;
  logic [DATA_W-1:0] back_q;

  assign msb = front_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      front_q <= FILL;
      back_q  <= FILL;
    end else if (push) begin
      front_q <= back_q;
      back_q  <= din;
    end else begin
      if (xfer)       front_q <= back_q;
      else if (shift) front_q <= {front_q[DATA_W-2:0], 1'b0};
      if (put)        back_q  <= din;
      else if (xfer)  back_q  <= FILL;
    end
  end
endmodule

// File: rtl/dtx_top.sv
module dtx_top
  import dtx_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_en,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  bit_period,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_n,
  output logic              ser_out,
  output logic              stat_d,
  output logic              stat_oe
);
  localparam logic [DATA_W-1:0] FILL = DATA_W'(PREAMBLE);

  logic en_q;
  logic rdy_q;
  logic tick;
  logic last;
  logic clear;
  logic push;
  logic accept;

  assign clear  = en_q && !tx_en;
  assign push   = !tx_en && buf_en && wr_stb;
  assign accept = tx_en && buf_en && wr_stb && rdy_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= tx_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) rdy_q <= 1'b1;
    else if (accept)   rdy_q <= 1'b0;
    else if (last)     rdy_q <= 1'b1;
  end

  dtx_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .run   (tx_en),
    .limit (bit_period),
    .tick  (tick)
  );

  dtx_bit_ctr #(.DATA_W(DATA_W)) u_bits (
    .clk  (clk),
    .rst  (rst),
    .run  (tx_en),
    .tick (tick),
    .last (last)
  );

  dtx_chain #(.DATA_W(DATA_W), .FILL(FILL)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .push  (push),
    .xfer  (last),
    .shift (tick && !last),
    .put   (accept),
    .din   (wr_data),
    .msb   (ser_out)
  );

  assign stat_d  = rdy_q;
  assign stat_oe = !cs_n;
endmodule

// File: rtl/dtx_checker.sv
module dtx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic buf_en,
  input logic wr_stb,
  input logic ser_out,
  input logic rdy_q,
  input logic en_q,
  input logic last
);
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> rdy_q);

  p_accept_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_en && buf_en && wr_stb && rdy_q) |=> !rdy_q);

  p_boundary_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && last && !(buf_en && wr_stb)) |=> rdy_q);

  p_drop_keeps_low_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !rdy_q && !last) |=> !rdy_q);

  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !en_q && !buf_en) |=> $stable(ser_out));
endmodule

bind dtx_top dtx_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .buf_en  (buf_en),
  .wr_stb  (wr_stb),
  .ser_out (ser_out),
  .rdy_q   (rdy_q),
  .en_q    (en_q),
  .last    (last)
);

// File: tb/dtx_top_tb_top.sv
module dtx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       buf_en = 1'b0;
  logic       tx_en = 1'b0;
  logic [7:0] bit_period = 8'd3;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cs_n = 1'b0;
  logic       ser_out;
  logic       stat_d;
  logic       stat_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtx_top dut_i (
    .clk(clk), .rst(rst), .buf_en(buf_en), .tx_en(tx_en),
    .bit_period(bit_period), .wr_stb(wr_stb), .wr_data(wr_data),
    .cs_n(cs_n), .ser_out(ser_out), .stat_d(stat_d), .stat_oe(stat_oe)
  );

  // behavioural reference: byte queue, bit position, prescaler count
  logic [7:0] m_q[$];
  int m_bit = 0;
  int m_pre = 0;
  bit m_rdy = 1'b1;
  bit m_en_prev = 1'b0;

  task automatic model_update();
    bit tk, bnd, acc;
    if (rst) begin
      m_q = '{8'hAA, 8'hAA}; m_bit = 0; m_pre = 0; m_rdy = 1'b1; m_en_prev = 1'b0;
      return;
    end
    if (!tx_en) begin
      if (m_en_prev) m_q = '{8'hAA, 8'hAA};
      else if (buf_en && wr_stb) begin
        void'(m_q.pop_front());
        m_q.push_back(wr_data);
      end
      m_bit = 0; m_pre = 0; m_rdy = 1'b1;
    end else begin
      tk  = (m_pre == int'(bit_period));
      bnd = tk && (m_bit == 7);
      acc = buf_en && wr_stb && m_rdy;
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_bit = bnd ? 0 : m_bit + 1;
      if (bnd) begin
        void'(m_q.pop_front());
        m_q.push_back(8'hAA);
        m_rdy = 1'b1;
      end
      if (acc) begin
        m_q[1] = wr_data;
        m_rdy = 1'b0;
      end
    end
    m_en_prev = tx_en;
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  string ser_tag = "R3";

  // R5 R6 R7 R9: compared every cycle after the model has advanced
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(ser_tag, ser_out, m_q[0][7-m_bit]);
    check("R7 stat_d", stat_d, m_rdy);
    check("R9 stat_oe", stat_oe, !cs_n);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(logic [7:0] b);
    wr_stb = 1'b1; wr_data = b;
    step();
    wr_stb = 1'b0;
  endtask

  initial begin
    steps(3);
    rst = 1'b0;
    step();
    check("R3 reset ser_out", ser_out, 1'b1);
    check("R3 reset ready", stat_d, 1'b1);

    // R1: writes with buffered mode off leave the preamble in place
    ser_tag = "R1";
    write(8'h55);
    write(8'h00);
    steps(2);
    check("R1 ignored write", ser_out, 1'b1);

    // R2: fill the chain before transmit
    buf_en = 1'b1;
    ser_tag = "R2";
    write(8'h3C);
    check("R2 first push ser_out", ser_out, 1'b1);
    write(8'hC3);
    check("R2 second push ser_out", ser_out, 1'b0);

    // R5 R7 R8: transmit; accepted write then dropped write
    ser_tag = "R5";
    tx_en = 1'b1;
    steps(5);
    write(8'h5A);
    check("R7 ready cleared", stat_d, 1'b0);
    write(8'hFF);
    check("R8 drop keeps ready low", stat_d, 1'b0);
    // R6: run through several bytes, the unwritten slot sends AAh
    ser_tag = "R6";
    steps(140);

    // R10: write exactly in a byte-transfer cycle while ready is high
    ser_tag = "R10";
    while (!(m_pre == int'(bit_period) && m_bit == 7 && m_rdy)) step();
    write(8'h96);
    check("R10 boundary write clears ready", stat_d, 1'b0);
    steps(40);

    // R9: status output released while chip select is high
    cs_n = 1'b1;
    step();
    check("R9 stat_oe low", stat_oe, 1'b0);
    cs_n = 1'b0;
    steps(5);

    // R4: disable transmit with a write in the same cycle
    ser_tag = "R4";
    tx_en = 1'b0;
    write(8'h0F);
    check("R4 reinit ser_out", ser_out, 1'b1);
    check("R4 ready idle", stat_d, 1'b1);

    // R3 R5: restart at a faster rate with no writes, preamble only
    bit_period = 8'd0;
    steps(2);
    ser_tag = "R3";
    tx_en = 1'b1;
    steps(24);
    tx_en = 1'b0;
    steps(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule